// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block holds two command words that travel between two independently clocked ports without entering the data queues. Port A deposits words into the first mailbox and collects words from the second. Port B deposits into the second and collects from the first. Each mailbox has an active-low full indicator, reported in the clock domain of the port that collects from it. While a mailbox holds an unread word, further deposits into it are refused.

Each port has a select/direction/enable control group and a mailbox-steer input. The steer input also chooses what the port's read data shows: the word from its data queue, or the mailbox it collects from. Port B deposits a mailbox word only when its two size bits both read 1 (full 36-bit width). The steer input plays no part in a port B deposit.

Each mailbox is set in the depositing domain and cleared in the collecting domain. This is done with a pair of toggle bits, and each toggle crosses through a two-stage synchronizer.

Top module: `mbx_pair`

## Requirements
- R1: After reset both full flags (`mail1_full_n`, `mail2_full_n`) are 1, meaning empty, and both mailbox words read as zero.
- R2: Mailbox 1 takes `a_din` on a `clk_a` rising edge only when `a_sel`, `a_wr`, `a_en` and `a_mbx` are all 1. `mail1_full_n` then goes to 0 after the second or third following `clk_b` rising edge.
- R3: Mailbox 2 takes `b_din` on a `clk_b` rising edge only when `b_sel`, `b_wr` and `b_en` are 1 and `b_size` equals 2'b11. `mail2_full_n` then goes to 0 after the second or third following `clk_a` rising edge.
- R4: A deposit attempted while the mailbox still holds an unread word is ignored, and the stored word is unchanged.
- R5: `a_dout` equals the mailbox 2 word when `a_mbx` is 1 and `fifo2_word` when `a_mbx` is 0. `a_oe` equals `a_sel` AND NOT `a_wr`.
- R6: `b_dout` equals the mailbox 1 word when `b_mbx` is 1 and `fifo1_word` when `b_mbx` is 0. `b_oe` equals `b_sel` AND NOT `b_wr`.
- R7: A collect is a reader-clock edge with the port's sel=1, wr=0, en=1 and mbx=1. A collect from a full mailbox sets its full flag back to 1 after that same edge.
- R8: A collect from an empty mailbox has no effect. The flag stays 1, and the next deposit is accepted and read back correctly.
- R9: A deposit made three or more writer-clock edges after the collecting edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_sel | input | 1 | Port A select |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A transfer enable |
| a_mbx | input | 1 | Port A mailbox steer |
| a_din | input | 36 | Port A write data |
| fifo2_word | input | 36 | Queue word offered to port A |
| a_dout | output | 36 | Port A read data |
| a_oe | output | 1 | Port A output active |
| mail2_full_n | output | 1 | Mailbox 2 full, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_sel | input | 1 | Port B select |
| b_wr | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B transfer enable |
| b_mbx | input | 1 | Port B mailbox steer for reads |
| b_size | input | 2 | Port B width code, 2'b11 = full width |
| b_din | input | 36 | Port B write data |
| fifo1_word | input | 36 | Queue word offered to port B |
| b_dout | output | 36 | Port B read data |
| b_oe | output | 1 | Port B output active |
| mail1_full_n | output | 1 | Mailbox 1 full, active low, clk_b domain |

## Verification
The bench sweeps all 16 port A control patterns and all 32 port B control-and-size patterns. A decode that accepts a partial size code, or ignores one control bit, deposits a word that should have been dropped. It repeats deposits while a word is unread. A missing lockout shows up as the newer word overwriting the first. It collects from an empty mailbox before depositing. A design that toggles its acknowledge on such a read would invert the flag sense and lose the next word. It also times how many reader edges the flag takes to fall. It checks that the flag rises on the collecting edge itself, and that the writer is released a few cycles later; a broken return path leaves the writer locked out.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    localparam int WORD_W      = 36;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_RSVD = 2'b10,
        SZ_LONG = 2'b11
    } size_code_t;

    typedef struct packed {
        logic sel;
        logic wr;
        logic en;
        logic mbx;
    } port_ctl_t;

    function automatic logic ctl_write(port_ctl_t c);
        return c.sel & c.wr & c.en;
    endfunction

    function automatic logic ctl_read(port_ctl_t c);
        return c.sel & ~c.wr & c.en;
    endfunction

    function automatic logic ctl_drive(port_ctl_t c);
        return c.sel & ~c.wr;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              clk_w,
    input  logic              rst_w,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] din,
    output logic              wr_busy,
    input  logic              clk_r,
    input  logic              rst_r,
    input  logic              rd_req,
    output logic [DATA_W-1:0] dout,
    output logic              full_n
);
    // writer side
    logic [DATA_W-1:0] data_q;
    logic              wr_tgl;
    logic              ack_seen;
    logic              wr_acc;

    // reader side
    logic              rd_tgl;
    logic              put_seen;
    logic              full;
    logic              rd_acc;

    assign wr_busy = wr_tgl ^ ack_seen;
    assign wr_acc  = wr_req & ~wr_busy;

    always_ff @(posedge clk_w) begin
        if (rst_w) begin
            data_q <= '0;
            wr_tgl <= 1'b0;
        end else if (wr_acc) begin
            data_q <= din;
            wr_tgl <= ~wr_tgl;
        end
    end

    mbx_sync #(.STAGES(STAGES)) u_put_sync (
        .clk (clk_r),
        .rst (rst_r),
        .d   (wr_tgl),
        .q   (put_seen)
    );

    mbx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk (clk_w),
        .rst (rst_w),
        .d   (rd_tgl),
        .q   (ack_seen)
    );

    assign full   = put_seen ^ rd_tgl;
    assign rd_acc = rd_req & full;

    always_ff @(posedge clk_r) begin
        if (rst_r)       rd_tgl <= 1'b0;
        else if (rd_acc) rd_tgl <= ~rd_tgl;
    end

    // word is frozen while the reader can see it as full
    assign dout   = data_q;
    assign full_n = ~full;

    a_r4_hold_while_busy: assert property (@(posedge clk_w) disable iff (rst_w)
        wr_busy |=> $stable(data_q));

    a_r2_busy_only_after_write: assert property (@(posedge clk_w) disable iff (rst_w)
        $rose(wr_busy) |-> $past(wr_req));

    a_r7_collect_empties: assert property (@(posedge clk_r) disable iff (rst_r)
        (rd_req && full) |=> full_n);

    a_r8_empty_read_noop: assert property (@(posedge clk_r) disable iff (rst_r)
        (rd_req && !full) |=> $stable(rd_tgl));
endmodule

// File: rtl/mbx_rdmux.sv
`timescale 1ns/1ps
module mbx_rdmux #(
    parameter int DATA_W = 36
) (
    input  logic              pick_mbx,
    input  logic [DATA_W-1:0] queue_word,
    input  logic [DATA_W-1:0] mbx_word,
    output logic [DATA_W-1:0] out_word
);
    always_comb begin
        if (pick_mbx) out_word = mbx_word;
        else          out_word = queue_word;
    end
endmodule

// File: rtl/mbx_pair.sv
`timescale 1ns/1ps
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] fifo2_word,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_oe,
    output logic              mail2_full_n,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [1:0]        b_size,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] fifo1_word,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_oe,
    output logic              mail1_full_n
);
    port_ctl_t ctl_a, ctl_b;
    logic a_put, a_get, b_put, b_get;
    logic m1_busy, m2_busy;
    logic [DATA_W-1:0] m1_word, m2_word;

    always_comb begin
        ctl_a.sel = a_sel; ctl_a.wr = a_wr; ctl_a.en = a_en; ctl_a.mbx = a_mbx;
        ctl_b.sel = b_sel; ctl_b.wr = b_wr; ctl_b.en = b_en; ctl_b.mbx = b_mbx;
    end

    assign a_put = ctl_write(ctl_a) & ctl_a.mbx;
    assign a_get = ctl_read(ctl_a)  & ctl_a.mbx;
    assign b_put = ctl_write(ctl_b) & (size_code_t'(b_size) == SZ_LONG);
    assign b_get = ctl_read(ctl_b)  & ctl_b.mbx;

    mbx_slot #(.DATA_W(DATA_W), .STAGES(STAGES)) u_mail1 (
        .clk_w (clk_a), .rst_w (rst_a), .wr_req (a_put), .din (a_din), .wr_busy (m1_busy),
        .clk_r (clk_b), .rst_r (rst_b), .rd_req (b_get), .dout (m1_word), .full_n (mail1_full_n)
    );

    mbx_slot #(.DATA_W(DATA_W), .STAGES(STAGES)) u_mail2 (
        .clk_w (clk_b), .rst_w (rst_b), .wr_req (b_put), .din (b_din), .wr_busy (m2_busy),
        .clk_r (clk_a), .rst_r (rst_a), .rd_req (a_get), .dout (m2_word), .full_n (mail2_full_n)
    );

    mbx_rdmux #(.DATA_W(DATA_W)) u_mux_a (
        .pick_mbx (a_mbx), .queue_word (fifo2_word), .mbx_word (m2_word), .out_word (a_dout)
    );

    mbx_rdmux #(.DATA_W(DATA_W)) u_mux_b (
        .pick_mbx (b_mbx), .queue_word (fifo1_word), .mbx_word (m1_word), .out_word (b_dout)
    );

    assign a_oe = ctl_drive(ctl_a);
    assign b_oe = ctl_drive(ctl_b);

    // R4: a refused deposit leaves the word port B sees unchanged
    a_r4_refused_keeps_word: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_put && m1_busy) |=> $stable(m1_word));

    a_r4_refused_keeps_word_b: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_put && m2_busy) |=> $stable(m2_word));
endmodule

// File: tb/mbx_pair_bench.sv
`timescale 1ns/1ps
module mbx_pair_bench;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    logic a_sel = 0, a_wr = 0, a_en = 0, a_mbx = 0;
    logic b_sel = 0, b_wr = 0, b_en = 0, b_mbx = 0;
    logic [1:0] b_size = 2'b00;
    logic [W-1:0] a_din = '0, b_din = '0, fifo1_word = '0, fifo2_word = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_oe, b_oe, mail1_full_n, mail2_full_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk_a = ~clk_a;
    initial begin
        #1.3;
        forever #3.5 clk_b = ~clk_b;
    end

    mbx_pair u_mbx_pair (
        .clk_a(clk_a), .rst_a(rst_a), .a_sel(a_sel), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx),
        .a_din(a_din), .fifo2_word(fifo2_word), .a_dout(a_dout), .a_oe(a_oe),
        .mail2_full_n(mail2_full_n),
        .clk_b(clk_b), .rst_b(rst_b), .b_sel(b_sel), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx),
        .b_size(b_size), .b_din(b_din), .fifo1_word(fifo1_word), .b_dout(b_dout), .b_oe(b_oe),
        .mail1_full_n(mail1_full_n)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_clear();
        a_sel = 0; a_wr = 0; a_en = 0; a_mbx = 0;
    endtask

    task automatic b_clear();
        b_sel = 0; b_wr = 0; b_en = 0; b_mbx = 0; b_size = 2'b00;
    endtask

    task automatic a_drive(logic s, logic w, logic e, logic m, logic [W-1:0] d);
        @(negedge clk_a);
        a_sel = s; a_wr = w; a_en = e; a_mbx = m; a_din = d;
        @(posedge clk_a);
        #1 a_clear();
    endtask

    task automatic b_drive(logic s, logic w, logic e, logic m, logic [1:0] sz, logic [W-1:0] d);
        @(negedge clk_b);
        b_sel = s; b_wr = w; b_en = e; b_mbx = m; b_size = sz; b_din = d;
        @(posedge clk_b);
        #1 b_clear();
    endtask

    task automatic read_mail1(logic [W-1:0] exp, string req);
        @(negedge clk_b);
        b_sel = 1; b_wr = 0; b_en = 1; b_mbx = 1;
        #0.5 chk({req, " mailbox1 word"}, b_dout, exp);
        @(posedge clk_b);
        #1 b_clear();
        @(negedge clk_b);
        chk("R7 mailbox1 flag back high", W'(mail1_full_n), W'(1));
    endtask

    task automatic read_mail2(logic [W-1:0] exp, string req);
        @(negedge clk_a);
        a_sel = 1; a_wr = 0; a_en = 1; a_mbx = 1;
        #0.5 chk({req, " mailbox2 word"}, a_dout, exp);
        @(posedge clk_a);
        #1 a_clear();
        @(negedge clk_a);
        chk("R7 mailbox2 flag back high", W'(mail2_full_n), W'(1));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        int n;
        repeat (4) @(posedge clk_a);
        repeat (4) @(posedge clk_b);
        @(negedge clk_a) rst_a = 0;
        @(negedge clk_b) rst_b = 0;
        repeat (2) @(negedge clk_a);

        // R1
        chk("R1 mail1 flag", W'(mail1_full_n), W'(1));
        chk("R1 mail2 flag", W'(mail2_full_n), W'(1));
        a_mbx = 1; b_mbx = 1;
        #0.5;
        chk("R1 mailbox2 zero", a_dout, '0);
        chk("R1 mailbox1 zero", b_dout, '0);
        a_mbx = 0; b_mbx = 0;

        // R5, R6
        fifo2_word = 36'h2A5A5A5A2;
        fifo1_word = 36'h1C3C3C3C1;
        for (int c = 0; c < 4; c++) begin
            a_sel = c[1]; a_wr = c[0]; a_en = 0;
            b_sel = c[1]; b_wr = c[0]; b_en = 0;
            #0.5;
            chk("R5 a_dout queue word", a_dout, fifo2_word);
            chk("R5 a_oe", W'(a_oe), W'(c == 2));
            chk("R6 b_dout queue word", b_dout, fifo1_word);
            chk("R6 b_oe", W'(b_oe), W'(c == 2));
        end
        a_clear(); b_clear();

        // R2 sweep of port A controls
        for (int c = 0; c < 16; c++) begin
            d = 36'h500000000 + W'(c) * 36'h1111;
            a_drive(c[3], c[2], c[1], c[0], d);
            repeat (4) @(negedge clk_b);
            chk("R2 mail1 flag after pattern", W'(mail1_full_n), W'(c != 15));
            if (c == 15) read_mail1(d, "R2");
            repeat (5) @(negedge clk_a);
        end

        // R3 sweep of port B controls and size
        for (int c = 0; c < 32; c++) begin
            d = 36'h600000000 + W'(c) * 36'h0101;
            b_drive(c[4], c[3], c[2], 1'b0, c[1:0], d);
            repeat (4) @(negedge clk_a);
            chk("R3 mail2 flag after pattern", W'(mail2_full_n), W'(c != 31));
            if (c == 31) read_mail2(d, "R3");
            repeat (5) @(negedge clk_b);
        end

        // R2 latency in clk_b edges
        @(negedge clk_a);
        a_sel = 1; a_wr = 1; a_en = 1; a_mbx = 1; a_din = 36'h0DEADBEEF;
        @(posedge clk_a);
        fork begin #1 a_clear(); end join_none
        n = 0;
        while (mail1_full_n && n < 10) begin
            @(posedge clk_b);
            #0.5 n++;
        end
        checks++;
        if (n < 2 || n > 3) begin
            errors++;
            $display("FAIL R2 flag latency: actual=%0d expected=2..3", n);
        end
        read_mail1(36'h0DEADBEEF, "R2");
        repeat (5) @(negedge clk_a);

        // R3 latency in clk_a edges
        @(negedge clk_b);
        b_sel = 1; b_wr = 1; b_en = 1; b_size = 2'b11; b_din = 36'h0CAFEF00D;
        @(posedge clk_b);
        fork begin #1 b_clear(); end join_none
        n = 0;
        while (mail2_full_n && n < 10) begin
            @(posedge clk_a);
            #0.5 n++;
        end
        checks++;
        if (n < 2 || n > 3) begin
            errors++;
            $display("FAIL R3 flag latency: actual=%0d expected=2..3", n);
        end
        read_mail2(36'h0CAFEF00D, "R3");
        repeat (5) @(negedge clk_b);

        // R4 lockout
        a_drive(1, 1, 1, 1, 36'h111111111);
        a_drive(1, 1, 1, 1, 36'h222222222);
        repeat (4) @(negedge clk_a);
        a_drive(1, 1, 1, 1, 36'h333333333);
        repeat (4) @(negedge clk_b);
        read_mail1(36'h111111111, "R4");
        repeat (5) @(negedge clk_a);
        b_drive(1, 1, 1, 0, 2'b11, 36'h444444444);
        b_drive(1, 1, 1, 0, 2'b11, 36'h555555555);
        repeat (4) @(negedge clk_b);
        b_drive(1, 1, 1, 0, 2'b11, 36'h666666666);
        repeat (4) @(negedge clk_a);
        read_mail2(36'h444444444, "R4");
        repeat (5) @(negedge clk_b);

        // R8 collect from empty mailbox
        b_drive(1, 0, 1, 1, 2'b00, '0);
        repeat (4) @(negedge clk_b);
        chk("R8 mail1 flag after empty read", W'(mail1_full_n), W'(1));
        repeat (4) @(negedge clk_a);
        a_drive(1, 1, 1, 1, 36'h777777777);
        repeat (4) @(negedge clk_b);
        chk("R8 mail1 flag after deposit", W'(mail1_full_n), W'(0));
        read_mail1(36'h777777777, "R8");
        a_drive(1, 0, 1, 1, '0);
        repeat (4) @(negedge clk_a);
        chk("R8 mail2 flag after empty read", W'(mail2_full_n), W'(1));
        b_drive(1, 1, 1, 0, 2'b11, 36'h888888888);
        repeat (4) @(negedge clk_a);
        chk("R8 mail2 flag after deposit", W'(mail2_full_n), W'(0));
        read_mail2(36'h888888888, "R8");

        // R9 writer released a few edges after the collect
        repeat (3) @(negedge clk_a);
        a_drive(1, 1, 1, 1, 36'h999999999);
        repeat (4) @(negedge clk_b);
        chk("R9 mail1 refilled", W'(mail1_full_n), W'(0));
        read_mail1(36'h999999999, "R9");
        repeat (3) @(negedge clk_b);
        b_drive(1, 1, 1, 0, 2'b11, 36'hABCABCABC);
        repeat (4) @(negedge clk_a);
        chk("R9 mail2 refilled", W'(mail2_full_n), W'(0));
        read_mail2(36'hABCABCABC, "R9");

        finish_run();
    end
endmodule